// File: doc/BRIEF.md
# PCI DMA Window Address Translator

This block sits between a PCI host bridge and system memory and turns each bus-side DMA address into a system physical address. It holds a set of programmable windows. Each window has a base, a size mask and a translated base. A window that matches the address either maps it directly by replacing the high bits with the translated base, or walks a one-level page table by reading a single 64-bit entry from memory. Two further ranges serve 64-bit dual-address-cycle traffic. One is a fixed one-to-one mapping. The other is a page-table path owned by the last window.

Software programs the windows and a control word through a simple register port. The bridge presents one bus address on the request port while the block is not busy. The block answers with a physical address and the mask of address bits that pass through unchanged, or with a fault. A fault means no window claimed the address, the address fell into the ISA hole, the entry read from memory was not valid, or the read reported an error. Only one translation is in flight at a time.

Top module: `dma_xlate`

## Requirements
- R1: After reset every register reads zero except the last window's base, which reads 2; the block is not busy and presents no response.
- R2: Register index encoding with four windows: 0-3 window bases, 4-7 size masks, 8-11 translated bases, 12 control. A write to windows 0-2 base keeps bits 31:20, 1 and 0 (0xFFF00003); a size mask keeps bits 31:20; a translated base keeps bits 34:10 (0x7FFFFFC00); control keeps 0x1CFF0FC7FF.
- R3: The last window's base keeps 0x80FFF00001 and always reads bit 1 as one, so that window always uses the page table. Its bit 39 selects dual-address mode.
- R4: For an address below 2^32, a window matches when base bit 0 is set and (address AND NOT(mask OR 0xFFFFF)) equals base bits 31:20. With base bit 1 clear the result is (tbase AND NOT ext) OR (address AND ext), and the returned mask is ext, where ext = mask OR 0xFFFFF.
- R5: When several windows match, the lowest-numbered one wins. The last window takes part in 32-bit matching only while its bit 39 is clear.
- R6: A matching window with base bit 1 set issues exactly one memory read. The read is at (tbase AND NOT(mask>>10)) OR ((address AND (mask OR 0xFE000))>>10), and the read address is held until the read completes.
- R7: A page-table entry with bit 0 set yields ((entry AND 0x3FFFFE)<<12) OR address bits 12:0, with mask 0x1FFF. An entry with bit 0 clear yields a fault.
- R8: While control bit 5 is set, 32-bit addresses 0x80000 through 0xFFFFF fault before any window is considered.
- R9: While control bit 6 is set, addresses in [0x100_0000_0000, 0x200_0000_0000) translate to address AND 0x7FF_FFFF_FFFF, with that value as the mask.
- R10: When the last window has bits 39 and 0 set, addresses 0x800_0000_0000 through 0xFFF_FFFF_FFFF read the entry at (tbase AND 0x7FFC00000) OR ((address AND 0xFFFFE000)>>10), and R7 applies to that entry.
- R11: An address claimed by nothing, or a memory read that returns an error, gives a fault. A fault response carries zero address and zero mask.
- R12: A request is accepted only while busy is low. A translation without a memory read responds in the second cycle after acceptance. The response lasts one cycle. Requests made while busy are ignored. A register write made in the lookup cycle does not affect that lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | SEL_W | Register index (see R2) |
| regWrData | input | 64 | Register write data |
| regRdData | output | 64 | Contents of the selected register |
| reqValid | input | 1 | Translation request |
| reqAddr | input | ADDR_W | Bus address to translate |
| reqBusy | output | 1 | A translation is in progress |
| memRdValid | output | 1 | Page-table entry read request |
| memRdAddr | output | MEM_AW | Physical address of the entry |
| memRdDone | input | 1 | Read completion |
| memRdErr | input | 1 | Read completed with an error |
| memRdData | input | 64 | Entry returned by memory |
| rspValid | output | 1 | Response strobe, one cycle |
| rspFault | output | 1 | Translation refused |
| rspAddr | output | PA_W | Translated physical address |
| rspMask | output | PA_W | Address bits passed through unchanged |

## Verification
Two things can happen in the same cycle. A register write can land in the very cycle a lookup decides its result, and a new request can be offered while an entry read is still outstanding. The bench drives a write that disables the matching window during the lookup cycle. It expects the answer built from the old settings, and then a fault on the next translation of the same address. It also raises a foreign request in the middle of a slow memory read. It then checks that the response still belongs to the original address and that no further response follows. Randomly programmed, overlapping windows run against a bench model of the priority and address rules, under random memory latency and injected errors.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  localparam logic [63:0] BaseKeep      = 64'h0000_0000_FFF0_0003;
  localparam logic [63:0] BaseLastKeep  = 64'h0000_0080_FFF0_0001;
  localparam logic [63:0] BaseLastForce = 64'h0000_0000_0000_0002;
  localparam logic [63:0] BaseField     = 64'h0000_0000_FFF0_0000;
  localparam logic [63:0] MaskKeep      = 64'h0000_0000_FFF0_0000;
  localparam logic [63:0] TbaseKeep     = 64'h0000_0007_FFFF_FC00;
  localparam logic [63:0] CtrlKeep      = 64'h0000_001C_FF0F_C7FF;
  localparam logic [63:0] FixedLow      = 64'h0000_0000_000F_FFFF;
  localparam logic [63:0] SgIdxLow      = 64'h0000_0000_000F_E000;
  localparam logic [63:0] PteFrame      = 64'h0000_0000_003F_FFFE;
  localparam logic [63:0] PageOffMask   = 64'h0000_0000_0000_1FFF;
  localparam logic [63:0] IsaLo         = 64'h0000_0000_0008_0000;
  localparam logic [63:0] IsaHi         = 64'h0000_0000_000F_FFFF;
  localparam logic [63:0] Wide64Lo      = 64'h0000_0100_0000_0000;
  localparam logic [63:0] Wide64End     = 64'h0000_0200_0000_0000;
  localparam logic [63:0] Wide64Mask    = 64'h0000_07FF_FFFF_FFFF;
  localparam logic [63:0] DualLo        = 64'h0000_0800_0000_0000;
  localparam logic [63:0] DualHi        = 64'h0000_0FFF_FFFF_FFFF;
  localparam logic [63:0] DualTbKeep    = 64'h0000_0007_FFC0_0000;
  localparam logic [63:0] DualIdxMask   = 64'h0000_0000_FFFF_E000;
  localparam int          DualBit       = 39;
  localparam int          CtlIsaBit     = 5;
  localparam int          CtlWideBit    = 6;

  typedef struct packed {
    logic latchReq;
    logic latchPte;
    logic rspLookup;
    logic rspPte;
  } dmxStrobe_t;

  typedef struct packed {
    logic        fault;
    logic        needPte;
    logic [63:0] physAddr;
    logic [63:0] physMask;
    logic [63:0] pteAddr;
  } dmxLookup_t;
endpackage

// File: rtl/dmx_win.sv
module dmx_win
  import dmx_pkg::*;
#(
  parameter bit IS_LAST = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrBase,
  input  logic        wrMask,
  input  logic        wrTbase,
  input  logic [63:0] wrData,
  input  logic [63:0] addr,
  output logic [63:0] baseQ,
  output logic [63:0] maskQ,
  output logic [63:0] tbaseQ,
  output logic        hit,
  output logic        sgMode,
  output logic [63:0] dmAddr,
  output logic [63:0] dmMask,
  output logic [63:0] pteAddr
);
  logic [63:0] ext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ  <= IS_LAST ? BaseLastForce : '0;
      maskQ  <= '0;
      tbaseQ <= '0;
    end else begin
      if (wrBase)  baseQ  <= IS_LAST ? ((wrData & BaseLastKeep) | BaseLastForce)
                                     : (wrData & BaseKeep);
      if (wrMask)  maskQ  <= wrData & MaskKeep;
      if (wrTbase) tbaseQ <= wrData & TbaseKeep;
    end
  end

  always_comb begin
    ext     = maskQ | FixedLow;
    hit     = baseQ[0] && ((addr & ~ext) == (baseQ & BaseField));
    sgMode  = baseQ[1];
    dmAddr  = (tbaseQ & ~ext) | (addr & ext);
    dmMask  = ext;
    pteAddr = (tbaseQ & ~(maskQ >> 10)) | ((addr & (maskQ | SgIdxLow)) >> 10);
  end
endmodule

// File: rtl/dmx_ctrl.sv
module dmx_ctrl
  import dmx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       needPte,
  input  logic       memRdDone,
  output dmxStrobe_t stb,
  output logic       fetching,
  output logic       busy
);
  typedef enum logic [1:0] {S_IDLE, S_LOOKUP, S_FETCH} dmxState_t;
  dmxState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    stb       = '0;
    case (state)
      S_IDLE: begin
        if (reqValid) begin
          stb.latchReq = 1'b1;
          stateNext    = S_LOOKUP;
        end
      end
      S_LOOKUP: begin
        if (needPte) begin
          stb.latchPte = 1'b1;
          stateNext    = S_FETCH;
        end else begin
          stb.rspLookup = 1'b1;
          stateNext     = S_IDLE;
        end
      end
      S_FETCH: begin
        if (memRdDone) begin
          stb.rspPte = 1'b1;
          stateNext  = S_IDLE;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  assign fetching = (state == S_FETCH);
  assign busy     = (state != S_IDLE);
endmodule

// File: rtl/dmx_dp.sv
module dmx_dp
  import dmx_pkg::*;
#(
  parameter int NWIN   = 4,
  parameter int ADDR_W = 44,
  parameter int PA_W   = 44,
  parameter int MEM_AW = 35,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [63:0]       regWrData,
  output logic [63:0]       regRdData,
  input  logic [ADDR_W-1:0] reqAddr,
  input  dmxStrobe_t        stb,
  output logic              needPte,
  input  logic              memRdErr,
  input  logic [63:0]       memRdData,
  output logic [MEM_AW-1:0] memRdAddr,
  output logic              rspValid,
  output logic              rspFault,
  output logic [PA_W-1:0]   rspAddr,
  output logic [PA_W-1:0]   rspMask
);
  localparam int CTL_IDX = 3 * NWIN;

  logic [NWIN-1:0][63:0] baseV, maskV, tbV, dmAddrV, dmMaskV, pteV;
  logic [NWIN-1:0]       hitV, sgV;
  logic [63:0]           ctlQ;
  logic [ADDR_W-1:0]     reqAddrQ;
  logic [63:0]           addr64;
  logic [MEM_AW-1:0]     pteAddrQ;
  logic                  rspValidQ, rspFaultQ, pteFault;
  logic [63:0]           rspAddrQ, rspMaskQ;
  dmxLookup_t            lk;

  assign addr64 = 64'(reqAddrQ);

  for (genvar g = 0; g < NWIN; g++) begin : gWin
    dmx_win #(.IS_LAST(g == NWIN - 1)) uWin (
      .clk     (clk),
      .rstN    (rstN),
      .wrBase  (regWrEn && (int'(regSel) == g)),
      .wrMask  (regWrEn && (int'(regSel) == NWIN + g)),
      .wrTbase (regWrEn && (int'(regSel) == 2 * NWIN + g)),
      .wrData  (regWrData),
      .addr    (addr64),
      .baseQ   (baseV[g]),
      .maskQ   (maskV[g]),
      .tbaseQ  (tbV[g]),
      .hit     (hitV[g]),
      .sgMode  (sgV[g]),
      .dmAddr  (dmAddrV[g]),
      .dmMask  (dmMaskV[g]),
      .pteAddr (pteV[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctlQ <= '0;
    else if (regWrEn && int'(regSel) == CTL_IDX) ctlQ <= regWrData & CtrlKeep;
  end

  always_comb begin
    regRdData = '0;
    for (int i = 0; i < NWIN; i++) begin
      if (int'(regSel) == i)            regRdData = baseV[i];
      if (int'(regSel) == NWIN + i)     regRdData = maskV[i];
      if (int'(regSel) == 2 * NWIN + i) regRdData = tbV[i];
    end
    if (int'(regSel) == CTL_IDX) regRdData = ctlQ;
  end

  // Lookup: all windows evaluated in parallel, lowest index wins
  always_comb begin
    lk       = '0;
    lk.fault = 1'b1;
    if (addr64[63:32] == '0) begin
      if (!(ctlQ[CtlIsaBit] && addr64 >= IsaLo && addr64 <= IsaHi)) begin
        for (int i = NWIN - 1; i >= 0; i--) begin
          if (hitV[i] && ((i != NWIN - 1) || !baseV[NWIN-1][DualBit])) begin
            lk.fault    = 1'b0;
            lk.needPte  = sgV[i];
            lk.physAddr = sgV[i] ? '0 : dmAddrV[i];
            lk.physMask = sgV[i] ? '0 : dmMaskV[i];
            lk.pteAddr  = pteV[i];
          end
        end
      end
    end else if (ctlQ[CtlWideBit] && addr64 >= Wide64Lo && addr64 < Wide64End) begin
      lk.fault    = 1'b0;
      lk.physAddr = addr64 & Wide64Mask;
      lk.physMask = Wide64Mask;
    end else if (addr64 >= DualLo && addr64 <= DualHi &&
                 baseV[NWIN-1][DualBit] && baseV[NWIN-1][0]) begin
      lk.fault   = 1'b0;
      lk.needPte = 1'b1;
      lk.pteAddr = (tbV[NWIN-1] & DualTbKeep) | ((addr64 & DualIdxMask) >> 10);
    end
  end

  assign needPte  = lk.needPte;
  assign pteFault = memRdErr || !memRdData[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqAddrQ  <= '0;
      pteAddrQ  <= '0;
      rspValidQ <= 1'b0;
      rspFaultQ <= 1'b0;
      rspAddrQ  <= '0;
      rspMaskQ  <= '0;
    end else begin
      rspValidQ <= stb.rspLookup || stb.rspPte;
      if (stb.latchReq) reqAddrQ <= reqAddr;
      if (stb.latchPte) pteAddrQ <= MEM_AW'(lk.pteAddr);
      if (stb.rspLookup) begin
        rspFaultQ <= lk.fault;
        rspAddrQ  <= lk.fault ? '0 : lk.physAddr;
        rspMaskQ  <= lk.fault ? '0 : lk.physMask;
      end
      if (stb.rspPte) begin
        rspFaultQ <= pteFault;
        rspAddrQ  <= pteFault ? '0 : (((memRdData & PteFrame) << 12) | (addr64 & PageOffMask));
        rspMaskQ  <= pteFault ? '0 : PageOffMask;
      end
    end
  end

  assign memRdAddr = pteAddrQ;
  assign rspValid  = rspValidQ;
  assign rspFault  = rspFaultQ;
  assign rspAddr   = PA_W'(rspAddrQ);
  assign rspMask   = PA_W'(rspMaskQ);
endmodule

// File: rtl/dma_xlate.sv
module dma_xlate
  import dmx_pkg::*;
#(
  parameter int NWIN   = 4,
  parameter int ADDR_W = 44,
  parameter int PA_W   = 44,
  parameter int MEM_AW = 35,
  parameter int SEL_W  = $clog2(3 * NWIN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [63:0]       regWrData,
  output logic [63:0]       regRdData,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqBusy,
  output logic              memRdValid,
  output logic [MEM_AW-1:0] memRdAddr,
  input  logic              memRdDone,
  input  logic              memRdErr,
  input  logic [63:0]       memRdData,
  output logic              rspValid,
  output logic              rspFault,
  output logic [PA_W-1:0]   rspAddr,
  output logic [PA_W-1:0]   rspMask
);
  dmxStrobe_t stb;
  logic       needPte;

  dmx_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .needPte   (needPte),
    .memRdDone (memRdDone),
    .stb       (stb),
    .fetching  (memRdValid),
    .busy      (reqBusy)
  );

  dmx_dp #(
    .NWIN(NWIN), .ADDR_W(ADDR_W), .PA_W(PA_W), .MEM_AW(MEM_AW), .SEL_W(SEL_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regSel    (regSel),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .reqAddr   (reqAddr),
    .stb       (stb),
    .needPte   (needPte),
    .memRdErr  (memRdErr),
    .memRdData (memRdData),
    .memRdAddr (memRdAddr),
    .rspValid  (rspValid),
    .rspFault  (rspFault),
    .rspAddr   (rspAddr),
    .rspMask   (rspMask)
  );
endmodule

// File: rtl/dmx_chk.sv
module dmx_chk #(
  parameter int MEM_AW = 35,
  parameter int PA_W   = 44
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqBusy,
  input logic              memRdValid,
  input logic [MEM_AW-1:0] memRdAddr,
  input logic              memRdDone,
  input logic              memRdErr,
  input logic              rspValid,
  input logic              rspFault,
  input logic [PA_W-1:0]   rspAddr,
  input logic [PA_W-1:0]   rspMask
);
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqBusy |=> reqBusy); // R12
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R12
  AST_READ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    memRdValid |-> reqBusy); // R6
  AST_READ_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    memRdValid && !memRdDone |=> memRdValid && $stable(memRdAddr)); // R6
  AST_READ_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    memRdValid |-> (memRdAddr[2:0] == 3'b000)); // R6
  AST_PAGE_MASK: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspFault && $past(memRdValid && memRdDone) |-> (rspMask == PA_W'(13'h1FFF))); // R7
  AST_ERR_FAULTS: assert property (@(posedge clk) disable iff (!rstN)
    memRdValid && memRdDone && memRdErr |=> rspValid && rspFault); // R11
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspFault |-> (rspAddr == '0) && (rspMask == '0)); // R11
endmodule

bind dma_xlate dmx_chk #(.MEM_AW(MEM_AW), .PA_W(PA_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqBusy    (reqBusy),
  .memRdValid (memRdValid),
  .memRdAddr  (memRdAddr),
  .memRdDone  (memRdDone),
  .memRdErr   (memRdErr),
  .rspValid   (rspValid),
  .rspFault   (rspFault),
  .rspAddr    (rspAddr),
  .rspMask    (rspMask)
);

// File: tb/sim_dma_xlate.sv
module sim_dma_xlate;
  localparam int ADDR_W = 44, PA_W = 44, MEM_AW = 35, SEL_W = 4;

  logic clk = 0, rstN = 0;
  logic regWrEn = 0;
  logic [SEL_W-1:0] regSel = 0;
  logic [63:0] regWrData = 0, regRdData;
  logic reqValid = 0, reqBusy;
  logic [ADDR_W-1:0] reqAddr = 0;
  logic memRdValid, memRdDone = 0, memRdErr = 0;
  logic [MEM_AW-1:0] memRdAddr;
  logic [63:0] memRdData = 0;
  logic rspValid, rspFault;
  logic [PA_W-1:0] rspAddr, rspMask;

  dma_xlate u0 (.*);

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  logic [63:0] sB[4], sM[4], sT[4], sC;

  typedef struct packed {
    logic fault; logic needPte;
    logic [63:0] addr; logic [63:0] mask; logic [63:0] pte;
  } exp_t;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] memOf(input logic [63:0] a);
    return (a * 64'h9E37_79B9_7F4A_7C15) ^ (a >> 7);
  endfunction

  function automatic void shadowApply(input int sel, input logic [63:0] d);
    if (sel < 3)       sB[sel] = d & 64'hFFF0_0003;
    else if (sel == 3) sB[3] = (d & 64'h80_FFF0_0001) | 64'h2;
    else if (sel < 8)  sM[sel-4] = d & 64'hFFF0_0000;
    else if (sel < 12) sT[sel-8] = d & 64'h7_FFFF_FC00;
    else if (sel == 12) sC = d & 64'h1C_FF0F_C7FF;
  endfunction

  function automatic logic [63:0] shadowOf(input int sel);
    if (sel < 4) return sB[sel];
    if (sel < 8) return sM[sel-4];
    if (sel < 12) return sT[sel-8];
    if (sel == 12) return sC;
    return 64'h0;
  endfunction

  function automatic exp_t model(input logic [63:0] a);
    exp_t r;
    r = '0; r.fault = 1'b1;
    if (a[63:32] == 0) begin
      if (sC[5] && a >= 64'h80000 && a <= 64'hFFFFF) return r;
      for (int i = 0; i < 4; i++) begin
        logic [63:0] ext;
        ext = sM[i] | 64'hFFFFF;
        if (i == 3 && sB[3][39]) continue;
        if (sB[i][0] && ((a & ~ext) == (sB[i] & 64'hFFF0_0000))) begin
          r.fault = 1'b0;
          if (sB[i][1]) begin
            r.needPte = 1'b1;
            r.pte = (sT[i] & ~(sM[i] >> 10)) | ((a & (sM[i] | 64'hFE000)) >> 10);
          end else begin
            r.addr = (sT[i] & ~ext) | (a & ext);
            r.mask = ext;
          end
          return r;
        end
      end
    end else if (sC[6] && a >= 64'h100_0000_0000 && a < 64'h200_0000_0000) begin
      r.fault = 1'b0;
      r.addr = a & 64'h7FF_FFFF_FFFF;
      r.mask = 64'h7FF_FFFF_FFFF;
    end else if (a >= 64'h800_0000_0000 && a <= 64'hFFF_FFFF_FFFF && sB[3][39] && sB[3][0]) begin
      r.fault = 1'b0; r.needPte = 1'b1;
      r.pte = (sT[3] & 64'h7_FFC0_0000) | ((a & 64'hFFFF_E000) >> 10);
    end
    return r;
  endfunction

  task automatic wrReg(input int sel, input logic [63:0] d);
    @(negedge clk);
    regWrEn = 1; regSel = SEL_W'(sel); regWrData = d;
    @(negedge clk);
    regWrEn = 0;
    shadowApply(sel, d);
  endtask

  task automatic rdChk(input int sel, input string req);
    @(negedge clk);
    regSel = SEL_W'(sel);
    #1 chk(req, regRdData, shadowOf(sel));
  endtask

  task automatic xlate(input logic [63:0] a, input int lat, input bit err,
                       input bit poke, input bit wrMid, input int wSel,
                       input logic [63:0] wData, input string tag);
    exp_t e;
    logic [63:0] pte, eAddr, eMask;
    bit fetched, f;
    int n, w;
    e = model(a);
    pte = 0; fetched = 0; n = 0; w = 0;
    @(negedge clk);
    reqValid = 1; reqAddr = a[ADDR_W-1:0];
    @(negedge clk);
    reqValid = 0;
    chk({"R12 busy after accept ", tag}, 64'(reqBusy), 64'h1);
    if (wrMid) begin regWrEn = 1; regSel = SEL_W'(wSel); regWrData = wData; end
    while (n < 60) begin
      @(negedge clk);
      n++;
      reqValid = 0; memRdDone = 0; memRdErr = 0;
      if (wrMid && n == 1) begin regWrEn = 0; shadowApply(wSel, wData); end
      if (rspValid) break;
      if (memRdValid) begin
        if (!fetched) begin
          fetched = 1;
          chk({"R6 entry address ", tag}, 64'(memRdAddr), e.pte);
          if (poke) begin reqValid = 1; reqAddr = ~a[ADDR_W-1:0]; end
        end
        if (w == lat) begin
          memRdDone = 1; memRdErr = err;
          memRdData = memOf(64'(memRdAddr));
          pte = memRdData;
        end
        w++;
      end
    end
    chk({"R6 read issued iff page-table path ", tag}, 64'(fetched), 64'(e.needPte));
    if (!e.needPte) chk({"R12 response latency ", tag}, 64'(n), 64'd1);
    chk({"R12 response seen ", tag}, 64'(rspValid), 64'h1);
    if (e.needPte) begin
      f = err || !pte[0];
      eAddr = f ? 64'h0 : (((pte & 64'h3F_FFFE) << 12) | (a & 64'h1FFF));
      eMask = f ? 64'h0 : 64'h1FFF;
    end else begin
      f = e.fault; eAddr = e.addr; eMask = e.mask;
    end
    chk({"R11 fault flag ", tag}, 64'(rspFault), 64'(f));
    chk({"R4 R7 physical address ", tag}, 64'(rspAddr), eAddr);
    chk({"R4 R7 pass mask ", tag}, 64'(rspMask), eMask);
    @(negedge clk);
    chk({"R12 single response ", tag}, 64'(rspValid), 64'h0);
  endtask

  task automatic go(input logic [63:0] a, input string tag);
    xlate(a, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [63:0] a;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) begin sB[i] = 0; sM[i] = 0; sT[i] = 0; end
    sB[3] = 64'h2; sC = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;

    // R1 reset state
    chk("R1 not busy", 64'(reqBusy), 0);
    chk("R1 no response", 64'(rspValid), 0);
    for (int s = 0; s <= 12; s++) rdChk(s, "R1 reset value");

    // R2 / R3 write masks
    wrReg(0, '1); rdChk(0, "R2 base keep");
    wrReg(5, '1); rdChk(5, "R2 size mask keep");
    wrReg(10, '1); rdChk(10, "R2 tbase keep");
    wrReg(12, '1); rdChk(12, "R2 control keep");
    wrReg(3, '1); rdChk(3, "R3 last base keep");
    wrReg(3, 0); rdChk(3, "R3 bit 1 forced");
    wrReg(0, 0); wrReg(5, 0); wrReg(10, 0); wrReg(12, 0);

    // R11 miss
    go(64'h1234, "R11 miss after reset");

    // R4 direct map
    wrReg(0, 64'h4000_0001); wrReg(4, 64'h0FF0_0000); wrReg(8, 64'h1_0000_0000);
    go(64'h4123_4567, "R4 direct");
    go(64'h4FFF_FFFF, "R4 window top");
    go(64'h5000_0000, "R11 past window");

    // R5 priority
    wrReg(1, 64'h4000_0001); wrReg(5, 64'h0); wrReg(9, 64'h2_0000_0000);
    go(64'h4001_0000, "R5 window 0 wins");
    wrReg(0, 0);
    go(64'h4001_0000, "R5 window 1 after 0 off");
    wrReg(3, 64'h6000_0001); wrReg(7, 0); wrReg(11, 64'h3_0000_0000);
    xlate(64'h6000_2345, 1, 0, 0, 0, 0, 0, "R5 last window 32-bit");
    wrReg(3, 64'h80_6000_0001);
    go(64'h6000_2345, "R5 last window off in dual mode");

    // R6 / R7 page table window
    wrReg(2, 64'h8000_0003); wrReg(6, 64'h0070_0000); wrReg(10, 64'h2_0000_4000);
    for (int k = 0; k < 6; k++)
      xlate(64'h8000_0000 + 64'(k) * 64'h13_5000 + 64'h123, k % 4, 0, 0, 0, 0, 0, "R7 entry");
    xlate(64'h8012_3456, 2, 1, 0, 0, 0, 0, "R11 read error");

    // R8 ISA hole
    wrReg(1, 64'h0000_0001); wrReg(5, 0); wrReg(9, 64'h5_0000_0000);
    wrReg(12, 64'h20);
    go(64'h7_FFFF, "R8 below hole");
    go(64'h8_0000, "R8 hole start");
    go(64'hF_FFFF, "R8 hole end");
    wrReg(12, 64'h0);
    go(64'h8_0000, "R8 hole disabled");

    // R9 wide direct range
    go(64'h100_0000_1000, "R9 off");
    wrReg(12, 64'h40);
    go(64'h100_0000_1000, "R9 low edge");
    go(64'h1FF_FFFF_FFFF, "R9 high edge");
    go(64'h200_0000_0000, "R9 past range");

    // R10 dual-address path
    wrReg(3, 64'h80_0000_0001); wrReg(11, 64'h7_FFFF_FC00);
    xlate(64'h800_1234_5678, 1, 0, 0, 0, 0, 0, "R10 low edge");
    xlate(64'hFFF_FFFF_FFFF, 0, 0, 0, 0, 0, 0, "R10 high edge");
    go(64'h7FF_FFFF_FFFF, "R10 below range");
    wrReg(3, 64'h80_0000_0000);
    go(64'h800_1234_5678, "R10 window disabled");

    // R12 ignored request while busy, write during lookup
    xlate(64'h8034_5678, 3, 0, 1, 0, 0, 0, "R12 request ignored while busy");
    wrReg(0, 64'hA000_0001); wrReg(4, 0); wrReg(8, 64'h4_0000_0000);
    xlate(64'hA00A_BCDE, 0, 0, 0, 1, 0, 64'h0, "R12 write during lookup");
    go(64'hA00A_BCDE, "R12 write took effect");

    // random mix
    for (int it = 0; it < 40; it++) begin
      for (int w = 0; w < 4; w++) begin
        logic [63:0] bf, mk;
        case ($urandom % 4)
          0: bf = 64'h0000_0000; 1: bf = 64'h1000_0000;
          2: bf = 64'h1800_0000; default: bf = 64'h8000_0000;
        endcase
        case ($urandom % 4)
          0: mk = 0; 1: mk = 64'h0010_0000;
          2: mk = 64'h00F0_0000; default: mk = 64'h0FF0_0000;
        endcase
        wrReg(w, bf | 64'($urandom % 4) | (($urandom % 3 == 0) ? 64'h80_0000_0000 : 0));
        wrReg(4 + w, mk);
        wrReg(8 + w, {$urandom, $urandom});
      end
      wrReg(12, 64'($urandom % 4) << 5);
      for (int t = 0; t < 6; t++) begin
        int k;
        k = $urandom % 6;
        if (k < 4) a = {32'h0, sB[k][31:20], 20'($urandom)} | (64'($urandom) & sM[k]);
        else if (k == 4) a = 64'h7_0000 + 64'($urandom % 32'h9_8000);
        else case ($urandom % 3)
          0: a = 64'h100_0000_0000 | ({$urandom, $urandom} & 64'hFF_FFFF_FFFF);
          1: a = 64'h800_0000_0000 | ({$urandom, $urandom} & 64'h7FF_FFFF_FFFF);
          default: a = {$urandom, $urandom} & 64'hFFF_FFFF_FFFF;
        endcase
        xlate(a, $urandom % 4, ($urandom % 8) == 0, 0, 0, 0, 0, "R4 R5 R6 random");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule